// File: doc/BRIEF.md
# Complementary Output Dead-Time Generator

This block turns one PWM reference into a pair of outputs: a main output that follows the reference and a complementary output that follows its inverse. A programmable gap is inserted at every reference edge. During the gap both outputs are inactive, so a half-bridge driven by the pair never has both switches on at once. The output that is turning off does so at once. The output that is turning on waits for the gap to expire.

The gap length is set by an 8-bit code and a 2-bit tick prescale. The upper bits of the code choose a piecewise range, which is a base offset plus a step multiplier. The prescale stretches the basic tick to one, two or four clocks. The code and the prescale are captured at each reference edge. Each output has its own enable. A single polarity input sets the active level of both outputs.

Top module: `dt_pair_gen`

## Requirements
- R1: While `rst` is high, both outputs are driven to the inactive level, which equals `pol_i`, one clock after it is applied.
- R2: When code bit 7 is 0, the gap is the code value, counted in ticks.
- R3: When code bits [7:6] are `10`, the gap is (64 + code[5:0]) x 2 ticks.
- R4: When code bits [7:5] are `110`, the gap is (32 + code[4:0]) x 8 ticks.
- R5: When code bits [7:5] are `111`, the gap is (32 + code[4:0]) x 16 ticks.
- R6: One tick lasts 1, 2 or 4 clocks for a prescale value of 0, 1 or 2. The value 3 also gives 4 clocks.
- R7: If `ref_i` is first sampled high at clock edge k and the gap is G clocks, `outn_o` goes inactive at edge k+1 and `out_o` goes active at edge k+1+G.
- R8: If `ref_i` is first sampled low at edge k, `out_o` goes inactive at edge k+1 and `outn_o` goes active at edge k+1+G.
- R9: A code of 0 makes the two outputs exact complements, with both changing at the same edge.
- R10: If a reference level lasts G clocks or fewer, the output that was waiting stays inactive for that whole level.
- R11: Code and prescale are sampled only at a reference edge. Changing them during a running gap leaves that gap's length unchanged.
- R12: With `pol_i`=0 the active level is 1. With `pol_i`=1 the active level is 0, and this applies to both outputs.
- R13: An output whose enable is 0 is held at the inactive level. The other output keeps working normally.
- R14: The two outputs are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_i | input | 1 | PWM reference |
| dt_code_i | input | 8 | Piecewise gap code |
| dt_div_i | input | 2 | Tick prescale: 0 gives x1, 1 gives x2, 2 and 3 give x4 |
| en_main_i | input | 1 | Main output enable |
| en_comp_i | input | 1 | Complementary output enable |
| pol_i | input | 1 | 1 selects active-low outputs |
| out_o | output | 1 | Main output, registered |
| outn_o | output | 1 | Complementary output, registered |

## Verification
The bench predicts the cycle of every output transition from the four code ranges and the three prescale factors. A design that decodes a range boundary wrongly, or ignores the prescale, moves the delayed edge and fails that comparison.

Pulses shorter than the gap, in both the high and the low phase, check that the waiting output stays inactive. A design that lets the counter carry over across edges would produce a stray sliver there. Changing the code in the middle of a gap catches a design that reads the code live instead of capturing it at the edge.

A zero code checks that both outputs switch in the same cycle. Polarity and enable changes check that a disabled output rests at the inactive level and that the other output still works.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int CODE_W = 8;
  localparam int DIV_W  = 2;
  localparam int TICK_W = 10;  // largest range: 63 x 16 = 1008 ticks

  typedef enum logic [DIV_W-1:0] {
    DTS_X1  = 2'd0,
    DTS_X2  = 2'd1,
    DTS_X4  = 2'd2,
    DTS_X4R = 2'd3
  } dts_div_e;
endpackage

// File: rtl/dtg_decode.sv
module dtg_decode
  import dtg_pkg::*;
#(
  parameter int GAP_W = 12
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic [GAP_W-1:0]  gap_o
);
  logic [TICK_W-1:0] ticks;
  logic [1:0]        sh;

  // piecewise range: the leading code bits select base and step
  always_comb begin
    if (!code_i[7])
      ticks = TICK_W'(code_i[6:0]);
    else if (!code_i[6])
      ticks = (TICK_W'(64) + TICK_W'(code_i[5:0])) << 1;
    else if (!code_i[5])
      ticks = (TICK_W'(32) + TICK_W'(code_i[4:0])) << 3;
    else
      ticks = (TICK_W'(32) + TICK_W'(code_i[4:0])) << 4;
  end

  always_comb begin
    case (dts_div_e'(div_i))
      DTS_X1:  sh = 2'd0;
      DTS_X2:  sh = 2'd1;
      default: sh = 2'd2;
    endcase
  end

  assign gap_o = GAP_W'(ticks) << sh;
endmodule

// File: rtl/dtg_gap_timer.sv
module dtg_gap_timer #(
  parameter int GAP_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_i,
  input  logic [GAP_W-1:0] gap_i,
  output logic             ref_q_o,
  output logic             main_raw_o,
  output logic             comp_raw_o
);
  logic             ref_q;
  logic [GAP_W-1:0] cnt;
  logic             expired;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= 1'b0;
      cnt   <= '0;
    end else begin
      ref_q <= ref_i;
      if (ref_i != ref_q)
        cnt <= gap_i;          // capture the gap at the edge only
      else if (cnt != '0)
        cnt <= cnt - 1'b1;
    end
  end

  assign expired    = (cnt == '0);
  assign ref_q_o    = ref_q;
  assign main_raw_o = ref_q & expired;
  assign comp_raw_o = ~ref_q & expired;
endmodule

// File: rtl/dtg_out_stage.sv
module dtg_out_stage #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pol_i,
  input  logic [LANES-1:0] raw_i,
  input  logic [LANES-1:0] en_i,
  output logic [LANES-1:0] act_o,
  output logic [LANES-1:0] pin_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        act_o[g] <= 1'b0;
        pin_o[g] <= pol_i;
      end else begin
        act_o[g] <= en_i[g] & raw_i[g];
        pin_o[g] <= pol_i ^ (en_i[g] & raw_i[g]);
      end
    end
  end
endmodule

// File: rtl/dt_pair_gen.sv
module dt_pair_gen
  import dtg_pkg::*;
#(
  parameter int GAP_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_i,
  input  logic [CODE_W-1:0] dt_code_i,
  input  logic [DIV_W-1:0]  dt_div_i,
  input  logic              en_main_i,
  input  logic              en_comp_i,
  input  logic              pol_i,
  output logic              out_o,
  output logic              outn_o
);
  logic [GAP_W-1:0] gap;
  logic             ref_q;
  logic             main_raw;
  logic             comp_raw;
  logic [1:0]       act_q;
  logic [1:0]       pins;

  dtg_decode #(.GAP_W(GAP_W)) u_dec (
    .code_i (dt_code_i),
    .div_i  (dt_div_i),
    .gap_o  (gap)
  );

  dtg_gap_timer #(.GAP_W(GAP_W)) u_tmr (
    .clk        (clk),
    .rst        (rst),
    .ref_i      (ref_i),
    .gap_i      (gap),
    .ref_q_o    (ref_q),
    .main_raw_o (main_raw),
    .comp_raw_o (comp_raw)
  );

  dtg_out_stage #(.LANES(2)) u_out (
    .clk   (clk),
    .rst   (rst),
    .pol_i (pol_i),
    .raw_i ({comp_raw, main_raw}),
    .en_i  ({en_comp_i, en_main_i}),
    .act_o (act_q),
    .pin_o (pins)
  );

  assign out_o  = pins[0];
  assign outn_o = pins[1];
endmodule

// File: rtl/dtg_chk.sv
module dtg_chk (
  input logic clk,
  input logic rst,
  input logic ref_i,
  input logic pol_i,
  input logic en_main_i,
  input logic en_comp_i,
  input logic ref_q,
  input logic act_m,
  input logic act_c,
  input logic out_o,
  input logic outn_o
);
  // R14
  excl_chk: assert property (@(posedge clk) disable iff (rst) !(act_m && act_c));

  // R13
  main_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en_main_i |=> out_o == $past(pol_i));

  // R13
  comp_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en_comp_i |=> outn_o == $past(pol_i));

  // R7
  comp_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ref_q) |=> !act_c);

  // R8
  main_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ref_q) |=> !act_m);

  // R10
  main_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(act_m) |-> $past(ref_i));
endmodule

bind dt_pair_gen dtg_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .ref_i     (ref_i),
  .pol_i     (pol_i),
  .en_main_i (en_main_i),
  .en_comp_i (en_comp_i),
  .ref_q     (ref_q),
  .act_m     (act_q[0]),
  .act_c     (act_q[1]),
  .out_o     (out_o),
  .outn_o    (outn_o)
);

// File: tb/dt_pair_gen_tb_top.sv
`timescale 1ns/1ps
module dt_pair_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_s = 1'b0;
  logic [7:0] code = 8'd0;
  logic [1:0] div = 2'd0;
  logic       en_m = 1'b1;
  logic       en_c = 1'b1;
  logic       pol = 1'b0;
  logic       out_w, outn_w;

  always #2.5 clk = ~clk;

  dt_pair_gen dut_i (
    .clk(clk), .rst(rst), .ref_i(ref_s), .dt_code_i(code), .dt_div_i(div),
    .en_main_i(en_m), .en_comp_i(en_c), .pol_i(pol), .out_o(out_w), .outn_o(outn_w)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int overlap = 0;
  bit mon_on = 0;
  bit exp_c = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // event kinds: 0 main rise, 1 main fall, 2 comp rise, 3 comp fall
  typedef struct {
    int    kind;
    int    t;
    string tag;
  } ev_t;
  ev_t expq[$];

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_gap(logic [7:0] c, logic [1:0] d);
    int ticks;
    if (!c[7])      ticks = int'(c);
    else if (!c[6]) ticks = (64 + int'(c[5:0])) * 2;
    else if (!c[5]) ticks = (32 + int'(c[4:0])) * 8;
    else            ticks = (32 + int'(c[4:0])) * 16;
    return ticks * ((d == 2'd0) ? 1 : (d == 2'd1) ? 2 : 4);
  endfunction

  task automatic push(int k, int t, string tag);
    ev_t e;
    e.kind = k; e.t = t; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic mon_event(int k);
    ev_t e;
    total++;
    if (expq.size() == 0) begin
      bad++;
      $display("FAIL R7/R8 unexpected kind=%0d actual=%0d expected=none", k, cyc);
    end else begin
      e = expq.pop_front();
      if (e.kind != k || e.t != cyc) begin
        bad++;
        $display("FAIL %s kind actual=%0d expected=%0d time actual=%0d expected=%0d",
                 e.tag, k, e.kind, cyc, e.t);
      end
    end
  endtask

  // monitor: derive active levels and compare transitions against the queue
  logic pm = 1'b0, pc = 1'b0;
  always @(negedge clk) begin : mon
    logic am, ac;
    am = out_w ^ pol;
    ac = outn_w ^ pol;
    if (mon_on) begin
      if (am && ac) overlap++;
      if (pm && !am) mon_event(1);
      if (pc && !ac) mon_event(3);
      if (!pm && am) mon_event(0);
      if (!pc && ac) mon_event(2);
    end
    pm = am;
    pc = ac;
  end

  // driver: one reference pulse, expected transitions queued from the requirements
  task automatic pulse(logic [7:0] cr, logic [7:0] cf, logic [1:0] d, int h, int l, string tag);
    int dr, df, t0;
    dr = exp_gap(cr, d);
    df = exp_gap(cf, d);
    @(negedge clk);
    t0 = cyc;
    code = cr; div = d; ref_s = 1'b1;
    if (exp_c) push(3, t0 + 2, tag);
    if (h > dr) begin
      push(0, t0 + 2 + dr, tag);
      push(1, t0 + h + 2, tag);
    end
    if (l > df) push(2, t0 + h + 2 + df, tag);
    exp_c = (l > df);
    @(negedge clk);
    code = cf;
    repeat (h - 1) @(negedge clk);
    ref_s = 1'b0;
    repeat (l - 1) @(negedge clk);
  endtask

  initial begin
    // R1: reset drives the inactive level for either polarity
    repeat (3) @(negedge clk);
    check(out_w == 1'b0 && outn_w == 1'b0, "R1 reset pol0", {out_w, outn_w}, 0);
    pol = 1'b1;
    @(negedge clk);
    check(out_w == 1'b1 && outn_w == 1'b1, "R1 reset pol1", {out_w, outn_w}, 3);
    pol = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    check(outn_w == 1'b1 && out_w == 1'b0, "R8 idle low ref", {out_w, outn_w}, 1);
    exp_c = 1;
    mon_on = 1;

    pulse(8'h00, 8'h00, 2'd0, 5, 5, "R9");
    pulse(8'h05, 8'h05, 2'd0, 12, 12, "R2");
    pulse(8'h7F, 8'h7F, 2'd0, 133, 133, "R2");
    pulse(8'h83, 8'h83, 2'd0, 140, 140, "R3");
    pulse(8'hC2, 8'hC2, 2'd0, 280, 280, "R4");
    pulse(8'hE1, 8'hE1, 2'd0, 535, 535, "R5");
    pulse(8'h05, 8'h05, 2'd1, 16, 16, "R6");
    pulse(8'h05, 8'h05, 2'd2, 26, 26, "R6");
    pulse(8'h05, 8'h05, 2'd3, 26, 26, "R6");
    pulse(8'hFF, 8'hFF, 2'd3, 4040, 4040, "R6");
    pulse(8'h14, 8'h14, 2'd0, 8, 30, "R10");
    pulse(8'h14, 8'h14, 2'd0, 30, 8, "R10");
    pulse(8'h14, 8'h14, 2'd0, 20, 30, "R10");
    pulse(8'h0A, 8'h03, 2'd0, 20, 20, "R11");
    pulse(8'h03, 8'h03, 2'd0, 10, 10, "R7");
    repeat (10) @(negedge clk);
    check(expq.size() == 0, "R7 all transitions seen", expq.size(), 0);

    // R12: active-low operation
    mon_on = 0;
    pol = 1'b1;
    repeat (4) @(negedge clk);
    check(out_w == 1'b1 && outn_w == 1'b0, "R12 idle levels", {out_w, outn_w}, 2);
    @(negedge clk);
    mon_on = 1;
    pulse(8'h04, 8'h04, 2'd0, 10, 10, "R12");
    repeat (8) @(negedge clk);
    check(expq.size() == 0, "R12 all transitions seen", expq.size(), 0);
    mon_on = 0;
    pol = 1'b0;
    repeat (4) @(negedge clk);

    // R13: per-output enables
    code = 8'h02; div = 2'd0;
    en_m = 1'b0;
    ref_s = 1'b1;
    repeat (10) @(negedge clk);
    check(out_w == 1'b0, "R13 main disabled held", out_w, 0);
    check(outn_w == 1'b0, "R13 comp off while ref high", outn_w, 0);
    ref_s = 1'b0;
    repeat (10) @(negedge clk);
    check(outn_w == 1'b1, "R13 comp works with main disabled", outn_w, 1);
    en_c = 1'b0;
    repeat (3) @(negedge clk);
    check(outn_w == 1'b0, "R13 comp disabled held", outn_w, 0);
    en_m = 1'b1;
    ref_s = 1'b1;
    repeat (10) @(negedge clk);
    check(out_w == 1'b1, "R13 main works with comp disabled", out_w, 1);
    ref_s = 1'b0;
    repeat (10) @(negedge clk);
    en_c = 1'b1;
    repeat (4) @(negedge clk);
    check(outn_w == 1'b1 && out_w == 1'b0, "R13 restored", {out_w, outn_w}, 1);

    check(overlap == 0, "R14 no overlap", overlap, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule